// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the digital control core of a single-wire CAN physical-layer device. Two mode-select pins, transmit data and a set of digitised analog flags come in: bus-dominant comparator, high-voltage wake detector, under-voltage, over-temperature and ground loss. Out go the bus driver controls, the receive data line with an output enable that stands in for an open-drain pin, the regulator-control line and the load-switch enable. All delays are counted on the block's own fixed clock.

The host selects sleep, normal, high-speed or high-voltage wake transmit. In sleep the regulator-control line is low, so the host is unpowered. A high-voltage level on the bus raises that line and powers the host. The host then has a fixed hold window to select a non-sleep mode. If it does not, the block drops back to sleep even when the wake level is still on the bus.

Every asynchronous input passes through a two-flop synchroniser. A new mode code must be seen on two consecutive synchronised samples before it takes effect.

Top module: `swc_mode_ctrl`

## Requirements
- R1: The mode code `mode_in` decodes as 2'b00 sleep, 2'b01 high-voltage wake transmit, 2'b10 high-speed transmit and 2'b11 normal. `wave_en` is 1 in modes 2'b11 and 2'b01 only. `drv_hv_sel` is 1 in mode 2'b01 only.
- R2: After reset the block is asleep: `cntl_out`=0, `drv_en`=0, `rxd_oe`=0 and `load_sw_en`=1.
- R3: A mode code present for only one clock is ignored. A mode code held steady takes effect within 8 clocks.
- R4: In every awake mode, `txd_in`=0 gives `drv_en`=1 and `drv_dom`=1, and `txd_in`=1 gives `drv_dom`=0. In sleep the driver is never enabled.
- R5: When transmit data returns to recessive, `drv_en` stays 1 for DRV_HOLD_CYCLES clocks and then goes to 0.
- R6: In an awake mode `rxd_oe`=1. `rxd_out` is 0 while `bus_dom_in` or `hv_wake_in` is 1, and 1 otherwise.
- R7: In sleep, `rxd_oe` is 0 unless a wake level is present. While the wake level is present, `rxd_oe` is 1 and `rxd_out` follows the bus. After the wake level drops, `rxd_oe` stays 1 for RX_RELEASE_CYCLES clocks and then goes to 0, unless a non-sleep mode has been selected by then.
- R8: A rising wake level while asleep sets `cntl_out`=1 within 4 clocks of the input change.
- R9: `cntl_out` stays 1 while a non-sleep mode is active, and for HOLD_CYCLES clocks after a wake event or after entry to mode 2'b00. After that it goes to 0 even if the wake level persists. It does not rise again until the wake level falls and rises once more.
- R10: While `uv_in`=1, `drv_en`=0 and `rxd_oe`=0.
- R11: While `ot_in`=1, `drv_en`=0. The receive path keeps working.
- R12: `load_sw_en` is 0 while `gnd_loss_in`=1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 2 | Mode-select pins |
| txd_in | input | 1 | Transmit data, 0 = dominant |
| bus_dom_in | input | 1 | Normal-level bus comparator, 1 = dominant |
| hv_wake_in | input | 1 | High-voltage wake level detected |
| uv_in | input | 1 | Supply under-voltage flag |
| ot_in | input | 1 | Over-temperature flag |
| gnd_loss_in | input | 1 | Loss-of-ground flag |
| drv_en | output | 1 | Bus driver enable |
| drv_dom | output | 1 | Drive the bus to dominant |
| drv_hv_sel | output | 1 | Select high-voltage drive level |
| wave_en | output | 1 | Enable slope shaping |
| rxd_out | output | 1 | Receive data, 0 = dominant bus |
| rxd_oe | output | 1 | Receive pin output enable (0 = released) |
| cntl_out | output | 1 | Regulator control, 1 = regulator on |
| load_sw_en | output | 1 | Load switch closed |

## Verification
A wrong hold counter shows at `cntl_out` as an early or late drop to sleep. It is visible about HOLD_CYCLES clocks after the wake or sleep-entry event, so the bench shortens that parameter. A wrong mode filter or wrong decode shows within a few clocks as a wrong `wave_en`, `drv_hv_sel` or driver enable. A stuck receive release counter shows at `rxd_oe` RX_RELEASE_CYCLES clocks after the wake level drops. A lost fault gate shows immediately as `drv_en` or `rxd_oe` still at 1 while the flag is set.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    M_SLEEP = 2'b00,
    M_HVWU  = 2'b01,
    M_FAST  = 2'b10,
    M_NORM  = 2'b11
  } swc_mode_e;

  function automatic logic mode_awake(input swc_mode_e m);
    return m != M_SLEEP;
  endfunction

  function automatic logic mode_shaped(input swc_mode_e m);
    return (m == M_NORM) || (m == M_HVWU);
  endfunction

  function automatic logic mode_hvdrive(input swc_mode_e m);
    return m == M_HVWU;
  endfunction

  // either comparator seeing a driven level means a dominant bus
  function automatic logic bus_dominant(input logic nrm, input logic hv);
    return nrm | hv;
  endfunction

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/swc_mode_filter.sv
module swc_mode_filter
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sync,
  output swc_mode_e  mode_act
);
  logic [1:0] cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand     <= 2'b00;
      mode_act <= M_SLEEP;
    end else begin
      cand <= mode_sync;
      if (mode_sync == cand) mode_act <= swc_mode_e'(mode_sync);
    end
  end
endmodule

// File: rtl/swc_pwr_seq.sv
module swc_pwr_seq
  import swc_pkg::*;
#(
  parameter int HOLD_CYCLES = 250000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  swc_mode_e mode_act,
  input  logic      hv_s,
  output logic      pwr_on,
  output logic      wake_evt,
  output logic      hold_expire
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYCLES);

  logic [HW-1:0] hold_cnt;
  logic          hv_prev;
  logic          awake;

  assign awake       = mode_awake(mode_act);
  assign wake_evt    = !pwr_on && hv_s && !hv_prev;
  assign hold_expire = pwr_on && !awake && (hold_cnt == HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      hv_prev  <= 1'b0;
      pwr_on   <= 1'b0;
    end else begin
      hv_prev <= hv_s;
      if (awake || wake_evt)            hold_cnt <= HOLD_LD;
      else if (pwr_on && hold_cnt != 0) hold_cnt <= hold_cnt - HW'(1);
      if (awake || wake_evt)            pwr_on <= 1'b1;
      else if (hold_expire)             pwr_on <= 1'b0;
    end
  end
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int RX_RELEASE_CYCLES = 20,
  parameter int DRV_HOLD_CYCLES   = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  swc_mode_e mode_act,
  input  logic      txd_s,
  input  logic      bus_s,
  input  logic      hv_s,
  input  logic      uv_s,
  input  logic      ot_s,
  output logic      tx_req,
  output logic      drv_en,
  output logic      drv_dom,
  output logic      drv_hv_sel,
  output logic      wave_en,
  output logic      rxd_out,
  output logic      rxd_oe
);
  localparam int RW = $clog2(RX_RELEASE_CYCLES + 1);
  localparam int DW = $clog2(DRV_HOLD_CYCLES + 1);
  localparam logic [RW-1:0] RX_LD  = RW'(RX_RELEASE_CYCLES);
  localparam logic [DW-1:0] DRV_LD = DW'(DRV_HOLD_CYCLES);

  logic          awake, drv_gate, rx_active;
  logic [RW-1:0] rx_cnt;
  logic [DW-1:0] drv_cnt;

  assign awake    = mode_awake(mode_act);
  assign tx_req   = awake && !txd_s;
  assign drv_gate = awake && !uv_s && !ot_s;

  // transmit side: keep the driver on briefly after going recessive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             drv_cnt <= '0;
    else if (tx_req)        drv_cnt <= DRV_LD;
    else if (drv_cnt != 0)  drv_cnt <= drv_cnt - DW'(1);
  end

  assign drv_en     = drv_gate && (tx_req || drv_cnt != 0);
  assign drv_dom    = drv_en && tx_req;
  assign wave_en    = mode_shaped(mode_act);
  assign drv_hv_sel = mode_hvdrive(mode_act);

  // receive side: in sleep, drive only around a wake level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_active <= 1'b0;
      rx_cnt    <= '0;
    end else if (awake) begin
      rx_active <= 1'b0;
      rx_cnt    <= '0;
    end else if (hv_s) begin
      rx_active <= 1'b1;
      rx_cnt    <= RX_LD;
    end else if (rx_active) begin
      if (rx_cnt <= RW'(1)) begin
        rx_active <= 1'b0;
        rx_cnt    <= '0;
      end else begin
        rx_cnt <= rx_cnt - RW'(1);
      end
    end
  end

  assign rxd_oe  = !uv_s && (awake || rx_active || hv_s);
  assign rxd_out = rxd_oe ? !bus_dominant(bus_s, hv_s) : 1'b1;
endmodule

// File: rtl/swc_mode_ctrl.sv
module swc_mode_ctrl
  import swc_pkg::*;
#(
  parameter int HOLD_CYCLES       = 250000,
  parameter int RX_RELEASE_CYCLES = 20,
  parameter int DRV_HOLD_CYCLES   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  input  logic       txd_in,
  input  logic       bus_dom_in,
  input  logic       hv_wake_in,
  input  logic       uv_in,
  input  logic       ot_in,
  input  logic       gnd_loss_in,
  output logic       drv_en,
  output logic       drv_dom,
  output logic       drv_hv_sel,
  output logic       wave_en,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       cntl_out,
  output logic       load_sw_en
);
  localparam int SW = 7;

  logic [SW-1:0] stat_sync;
  logic [1:0]    mode_sync;
  logic          bus_s, hv_s, uv_s, ot_s, gnd_s, txd_s;
  swc_mode_e     mode_act;
  logic          pwr_on, wake_evt, hold_expire, tx_req;

  swc_sync #(.W(SW), .RST_VAL('0)) u_sync_stat (
    .clk(clk), .rst_n(rst_n),
    .d({mode_in, bus_dom_in, hv_wake_in, uv_in, ot_in, gnd_loss_in}),
    .q(stat_sync)
  );

  swc_sync #(.W(1), .RST_VAL(1'b1)) u_sync_txd (
    .clk(clk), .rst_n(rst_n), .d(txd_in), .q(txd_s)
  );

  assign {mode_sync, bus_s, hv_s, uv_s, ot_s, gnd_s} = stat_sync;

  swc_mode_filter u_filt (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .mode_act(mode_act)
  );

  swc_pwr_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .mode_act(mode_act), .hv_s(hv_s),
    .pwr_on(pwr_on), .wake_evt(wake_evt), .hold_expire(hold_expire)
  );

  swc_datapath #(
    .RX_RELEASE_CYCLES(RX_RELEASE_CYCLES),
    .DRV_HOLD_CYCLES(DRV_HOLD_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .mode_act(mode_act), .txd_s(txd_s),
    .bus_s(bus_s), .hv_s(hv_s), .uv_s(uv_s), .ot_s(ot_s),
    .tx_req(tx_req), .drv_en(drv_en), .drv_dom(drv_dom),
    .drv_hv_sel(drv_hv_sel), .wave_en(wave_en),
    .rxd_out(rxd_out), .rxd_oe(rxd_oe)
  );

  assign cntl_out   = pwr_on;
  assign load_sw_en = !gnd_s;
endmodule

// File: rtl/swc_mode_ctrl_chk.sv
module swc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_act,
  input logic       uv_s,
  input logic       ot_s,
  input logic       tx_req,
  input logic       wake_evt,
  input logic       hold_expire,
  input logic       drv_en,
  input logic       drv_dom,
  input logic       drv_hv_sel,
  input logic       wave_en,
  input logic       rxd_oe,
  input logic       cntl_out
);
  // R10
  uv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |-> (!drv_en && !rxd_oe));

  // R11
  ot_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |-> !drv_en);

  // R8
  wake_cntl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> cntl_out);

  // R9
  expire_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_expire |=> !cntl_out);

  // R9
  awake_cntl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act != 2'b00) |=> cntl_out);

  // R4
  dom_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_dom |-> (drv_en && tx_req));

  // R4
  sleep_no_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == 2'b00) |-> !drv_en);

  // R1
  hv_shaped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_hv_sel |-> wave_en);

  // R5
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_req) && $stable(mode_act) && (mode_act != 2'b00) && !uv_s && !ot_s) |-> drv_en);
endmodule

bind swc_mode_ctrl swc_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_act(mode_act), .uv_s(uv_s), .ot_s(ot_s),
  .tx_req(tx_req), .wake_evt(wake_evt), .hold_expire(hold_expire),
  .drv_en(drv_en), .drv_dom(drv_dom), .drv_hv_sel(drv_hv_sel),
  .wave_en(wave_en), .rxd_oe(rxd_oe), .cntl_out(cntl_out)
);

// File: tb/swc_mode_ctrl_bench.sv
`timescale 1ns/1ps
module swc_mode_ctrl_bench;
  localparam int HOLD = 60;
  localparam int RXR  = 20;
  localparam int DRH  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic       txd_in = 1'b1, bus_dom_in = 1'b0, hv_wake_in = 1'b0;
  logic       uv_in = 1'b0, ot_in = 1'b0, gnd_loss_in = 1'b0;
  logic       drv_en, drv_dom, drv_hv_sel, wave_en, rxd_out, rxd_oe, cntl_out, load_sw_en;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  swc_mode_ctrl #(.HOLD_CYCLES(HOLD), .RX_RELEASE_CYCLES(RXR), .DRV_HOLD_CYCLES(DRH)) u_swc_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .txd_in(txd_in),
    .bus_dom_in(bus_dom_in), .hv_wake_in(hv_wake_in), .uv_in(uv_in),
    .ot_in(ot_in), .gnd_loss_in(gnd_loss_in), .drv_en(drv_en),
    .drv_dom(drv_dom), .drv_hv_sel(drv_hv_sel), .wave_en(wave_en),
    .rxd_out(rxd_out), .rxd_oe(rxd_oe), .cntl_out(cntl_out),
    .load_sw_en(load_sw_en)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_in = m;
    cyc(8);
  endtask

  task automatic go_sleep();
    txd_in = 1'b1; hv_wake_in = 1'b0; bus_dom_in = 1'b0;
    set_mode(2'b00);
    cyc(HOLD + 10);
  endtask

  task automatic t_reset();
    check("R2", "cntl_out", cntl_out, 1'b0);
    check("R2", "drv_en", drv_en, 1'b0);
    check("R2", "rxd_oe", rxd_oe, 1'b0);
    check("R2", "load_sw_en", load_sw_en, 1'b1);
  endtask

  task automatic t_glitch();
    mode_in = 2'b11;
    cyc(1);
    mode_in = 2'b00;
    cyc(8);
    check("R3", "cntl after 1-clock mode pulse", cntl_out, 1'b0);
    check("R3", "wave_en after pulse", wave_en, 1'b0);
    mode_in = 2'b11;
    cyc(8);
    check("R3", "cntl after steady mode", cntl_out, 1'b1);
    go_sleep();
  endtask

  task automatic t_modes();
    for (int i = 0; i < 3; i++) begin
      logic [1:0] m;
      m = (i == 0) ? 2'b11 : (i == 1) ? 2'b10 : 2'b01;
      set_mode(m);
      check("R1", $sformatf("wave_en mode %b", m), wave_en, m != 2'b10);
      check("R1", $sformatf("drv_hv_sel mode %b", m), drv_hv_sel, m == 2'b01);
      txd_in = 1'b0; cyc(4);
      check("R4", $sformatf("drv_en txd0 mode %b", m), drv_en, 1'b1);
      check("R4", $sformatf("drv_dom txd0 mode %b", m), drv_dom, 1'b1);
      txd_in = 1'b1; cyc(4);
      check("R4", $sformatf("drv_dom txd1 mode %b", m), drv_dom, 1'b0);
      cyc(6);
      check("R4", $sformatf("drv_en idle mode %b", m), drv_en, 1'b0);
      bus_dom_in = 1'b1; cyc(4);
      check("R6", $sformatf("rxd_oe mode %b", m), rxd_oe, 1'b1);
      check("R6", $sformatf("rxd dominant mode %b", m), rxd_out, 1'b0);
      bus_dom_in = 1'b0; cyc(4);
      check("R6", $sformatf("rxd recessive mode %b", m), rxd_out, 1'b1);
    end
    hv_wake_in = 1'b1; cyc(4);
    check("R6", "rxd low on wake level", rxd_out, 1'b0);
    hv_wake_in = 1'b0; cyc(4);
  endtask

  task automatic t_drv_hold();
    set_mode(2'b11);
    txd_in = 1'b0; cyc(6);
    txd_in = 1'b1; cyc(4);
    check("R5", "drv_en inside hold", drv_en, 1'b1);
    check("R5", "drv_dom inside hold", drv_dom, 1'b0);
    cyc(6);
    check("R5", "drv_en after hold", drv_en, 1'b0);
  endtask

  task automatic t_uv_ot_gnd();
    set_mode(2'b11);
    txd_in = 1'b0; cyc(4);
    uv_in = 1'b1; cyc(4);
    check("R10", "drv_en under uv", drv_en, 1'b0);
    check("R10", "rxd_oe under uv", rxd_oe, 1'b0);
    uv_in = 1'b0; cyc(4);
    check("R10", "drv_en after uv", drv_en, 1'b1);
    ot_in = 1'b1; bus_dom_in = 1'b1; cyc(4);
    check("R11", "drv_en under ot", drv_en, 1'b0);
    check("R11", "rxd_oe under ot", rxd_oe, 1'b1);
    check("R11", "rxd_out under ot", rxd_out, 1'b0);
    ot_in = 1'b0; bus_dom_in = 1'b0; txd_in = 1'b1;
    gnd_loss_in = 1'b1; cyc(4);
    check("R12", "load open", load_sw_en, 1'b0);
    gnd_loss_in = 1'b0; cyc(4);
    check("R12", "load closed", load_sw_en, 1'b1);
    go_sleep();
  endtask

  task automatic t_wake_rx();
    check("R7", "rxd released in sleep", rxd_oe, 1'b0);
    hv_wake_in = 1'b1; bus_dom_in = 1'b1; cyc(4);
    check("R8", "cntl on wake", cntl_out, 1'b1);
    check("R7", "rxd_oe with wake level", rxd_oe, 1'b1);
    check("R7", "rxd_out with wake level", rxd_out, 1'b0);
    hv_wake_in = 1'b0; bus_dom_in = 1'b0; cyc(10);
    check("R7", "rxd_oe inside release delay", rxd_oe, 1'b1);
    cyc(RXR);
    check("R7", "rxd_oe after release delay", rxd_oe, 1'b0);
    cyc(HOLD);
    check("R9", "cntl after wake hold", cntl_out, 1'b0);
  endtask

  task automatic t_hold_bus_high();
    hv_wake_in = 1'b1; cyc(4);
    check("R8", "cntl on second wake", cntl_out, 1'b1);
    cyc(HOLD - 10);
    check("R9", "cntl inside hold", cntl_out, 1'b1);
    cyc(20);
    check("R9", "cntl after hold, wake still high", cntl_out, 1'b0);
    cyc(20);
    check("R9", "no rewake on held level", cntl_out, 1'b0);
    check("R7", "rxd_oe while wake level present", rxd_oe, 1'b1);
    hv_wake_in = 1'b0; cyc(RXR + 10);
  endtask

  task automatic t_mode_keeps_rx();
    hv_wake_in = 1'b1; cyc(4);
    set_mode(2'b11);
    hv_wake_in = 1'b0; cyc(RXR + 10);
    check("R7", "rxd_oe kept by awake mode", rxd_oe, 1'b1);
    cyc(HOLD + 10);
    check("R9", "cntl held by awake mode", cntl_out, 1'b1);
    set_mode(2'b00);
    cyc(HOLD - 20);
    check("R9", "cntl inside hold after sleep entry", cntl_out, 1'b1);
    cyc(30);
    check("R9", "cntl after sleep-entry hold", cntl_out, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_glitch();
    t_modes();
    t_drv_hold();
    t_uv_ot_gnd();
    t_wake_rx();
    t_hold_bus_high();
    t_mode_keeps_rx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule